// File: doc/BRIEF.md
# Write-Per-Bit Mask Controller

This block turns each write command aimed at a 16-bit-wide memory array into a per-bit write-enable vector. Each byte-enable input gates one byte of the word. When the command also raises the write-per-bit request, a bit mask is applied on top of the byte gating. A mask bit of 1 lets its bit be written and a 0 protects it.

The mask can come from two places. In the default, non-persistent mode, the mask is the value on the data bus in the cycle the masked write is issued. A load-mask command stores a mask in a register and switches the controller to persistent mode. From then on every masked write uses the stored word and ignores the bus. Persistent mode ends only with a refresh command that carries the option-reset flag. A plain refresh changes nothing. The result is registered and drives the array's write enables on the cycle after the command.

Top module: `wpb_mask_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `wr_en_out` is all zeros and the controller is in non-persistent mode.
- R2: `wr_en_out` shows the result for a command sampled at one rising edge of `clk` from that edge until the next. It is all zeros whenever `cmd_valid` was low or `cmd_op` was not the write code 3'd1.
- R3: A write (`cmd_op` = 3'd1) with `wpb_req` low applies no bit mask, in either mode. The output is just the byte gating.
- R4: In non-persistent mode a write with `wpb_req` high uses `data_in` from the same cycle as the bit mask (1 = write, 0 = protect).
- R5: A load-mask command (`cmd_op` = 3'd2) stores `data_in` as the mask, enters persistent mode and gives an all-zero output.
- R6: In persistent mode a write with `wpb_req` high uses the stored mask, and the value on `data_in` has no effect. A later load-mask command replaces the stored mask.
- R7: A refresh without option reset (`cmd_op` = 3'd3) leaves the mode and the stored mask unchanged and gives an all-zero output.
- R8: A refresh with option reset (`cmd_op` = 3'd4) returns the controller to non-persistent mode.
- R9: `byte_en[0]` gates output bits 7:0 and `byte_en[1]` gates bits 15:8. A cleared byte enable forces those eight bits to zero whatever the mask.
- R10: Opcodes 3'd0, 3'd5, 3'd6 and 3'd7 change no state and give an all-zero output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code |
| data_in | input | 16 | Data bus, carrying the mask for masked writes and load-mask commands |
| byte_en | input | 2 | Byte enables, one for each 8-bit half |
| wpb_req | input | 1 | Write-per-bit request for a write command |
| wr_en_out | output | 16 | Registered per-bit write enable |

## Verification
Every command, including idle and non-write cycles, has exactly one result. That result is due on `wr_en_out` one rising edge after the command is sampled, because a single register stage sits on the path. The driver applies inputs on the falling edge and queues the expected word at that moment. The monitor pops one entry just after each following rising edge and compares it, so each result is checked in the cycle it becomes valid. Mode changes from load-mask and refresh commands are checked through the masked writes that follow them.

// File: rtl/wpb_mask_pkg.sv
package wpb_mask_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP         = 3'd0,
    OP_WRITE       = 3'd1,
    OP_LOAD_MASK   = 3'd2,
    OP_REFRESH     = 3'd3,
    OP_REFRESH_CLR = 3'd4
  } wpb_op_e;
endpackage

// File: rtl/wpb_mode_reg.sv
module wpb_mode_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic              persist_o,
  output logic [DATA_W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      persist_o <= 1'b0;
      mask_o    <= '1;
    end else if (load_i) begin
      persist_o <= 1'b1;
      mask_o    <= load_val_i;
    end else if (clear_i) begin
      persist_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wpb_lane_gate.sv
module wpb_lane_gate #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic [DATA_W-1:0] bit_mask_i,
  input  logic [LANES-1:0]  lane_en_i,
  output logic [DATA_W-1:0] wr_en_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        wr_en_o[g*LANE_W +: LANE_W] <= '0;
      end else if (fire_i && lane_en_i[g]) begin
        wr_en_o[g*LANE_W +: LANE_W] <= bit_mask_i[g*LANE_W +: LANE_W];
      end else begin
        wr_en_o[g*LANE_W +: LANE_W] <= '0;
      end
    end
  end
endmodule

// File: rtl/wpb_mask_ctrl.sv
module wpb_mask_ctrl #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OP_W  = wpb_mask_pkg::OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [DATA_W-1:0] data_in,
  input  logic [LANES-1:0]  byte_en,
  input  logic              wpb_req,
  output logic [DATA_W-1:0] wr_en_out
);
  import wpb_mask_pkg::*;

  logic              is_write, is_load, is_clear;
  logic              persist;
  logic [DATA_W-1:0] stored_mask;
  logic [DATA_W-1:0] bit_mask;

  assign is_write = cmd_valid && (cmd_op == OP_WRITE);
  assign is_load  = cmd_valid && (cmd_op == OP_LOAD_MASK);
  assign is_clear = cmd_valid && (cmd_op == OP_REFRESH_CLR);

  always_comb begin
    if (!wpb_req)     bit_mask = '1;
    else if (persist) bit_mask = stored_mask;
    else              bit_mask = data_in;
  end

  wpb_mode_reg #(.DATA_W(DATA_W)) mode_i (
    .clk       (clk),
    .rst       (rst),
    .load_i    (is_load),
    .clear_i   (is_clear),
    .load_val_i(data_in),
    .persist_o (persist),
    .mask_o    (stored_mask)
  );

  wpb_lane_gate #(.DATA_W(DATA_W), .LANE_W(LANE_W)) gate_i (
    .clk       (clk),
    .rst       (rst),
    .fire_i    (is_write),
    .bit_mask_i(bit_mask),
    .lane_en_i (byte_en),
    .wr_en_o   (wr_en_out)
  );
endmodule

// File: rtl/wpb_mask_ctrl_chk.sv
module wpb_mask_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int OP_W  = wpb_mask_pkg::OP_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [OP_W-1:0]   cmd_op,
  input logic [DATA_W-1:0] data_in,
  input logic [LANES-1:0]  byte_en,
  input logic              wpb_req,
  input logic [DATA_W-1:0] wr_en_out
);
  import wpb_mask_pkg::*;

  assert_nonwrite_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid || cmd_op != OP_WRITE) |=> wr_en_out == '0);

  assert_low_byte_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRITE && !byte_en[0]) |=> wr_en_out[LANE_W-1:0] == '0);

  assert_plain_write_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRITE && !wpb_req && byte_en == '1) |=> wr_en_out == '1);

  assert_stored_mask_used_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRITE && wpb_req && byte_en == '1 &&
     $past(cmd_valid) && $past(cmd_op) == OP_LOAD_MASK)
    |=> wr_en_out == $past(data_in, 2));

  assert_clear_to_bus_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_WRITE && wpb_req && byte_en == '1 &&
     $past(cmd_valid) && $past(cmd_op) == OP_REFRESH_CLR)
    |=> wr_en_out == $past(data_in));
endmodule

bind wpb_mask_ctrl wpb_mask_ctrl_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) chk_i (.*);

// File: tb/wpb_mask_ctrl_tb_top.sv
module wpb_mask_ctrl_tb_top;
  localparam int DATA_W = 16;
  localparam int LANES  = 2;

  typedef struct {
    logic [DATA_W-1:0] exp;
    string             tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = '0;
  logic [DATA_W-1:0] data_in = '0;
  logic [LANES-1:0]  byte_en = '0;
  logic              wpb_req = 1'b0;
  logic [DATA_W-1:0] wr_en_out;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;
  item_t pend[$];

  logic              m_persist = 1'b0;
  logic [DATA_W-1:0] m_mask = '1;

  always #2 clk = ~clk;

  wpb_mask_ctrl dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .data_in(data_in), .byte_en(byte_en), .wpb_req(wpb_req), .wr_en_out(wr_en_out)
  );

  task automatic issue(input logic v, input logic [2:0] op, input logic [DATA_W-1:0] d,
                       input logic [1:0] be, input logic req, input string tag);
    item_t             it;
    logic [DATA_W-1:0] m;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; data_in = d; byte_en = be; wpb_req = req;
    it.exp = '0;
    if (v && op == 3'd1) begin
      m = !req ? '1 : (m_persist ? m_mask : d);
      it.exp = m & {{8{be[1]}}, {8{be[0]}}};
    end
    if (v && op == 3'd2) begin m_mask = d; m_persist = 1'b1; end
    if (v && op == 3'd4) m_persist = 1'b0;
    it.tag = tag;
    pend.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (pend.size() > 0) begin
        it = pend.pop_front();
        n_checks++;
        if (wr_en_out !== it.exp) begin
          n_errors++;
          $display("FAIL %s: wr_en_out actual=%h expected=%h", it.tag, wr_en_out, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (wr_en_out !== '0) begin
      n_errors++;
      $display("FAIL R1: reset output actual=%h expected=0000", wr_en_out);
    end
    @(negedge clk);
    rst = 1'b0;
    issue(1, 3'd1, 16'h00FF, 2'b11, 1, "R1");
    issue(1, 3'd1, 16'h1234, 2'b11, 0, "R3");
    issue(1, 3'd1, 16'h0000, 2'b01, 0, "R9");
    issue(1, 3'd1, 16'h0000, 2'b10, 0, "R9");
    issue(1, 3'd1, 16'hFFFF, 2'b00, 0, "R9");
    issue(1, 3'd1, 16'hA5C3, 2'b11, 1, "R4");
    issue(1, 3'd1, 16'hF0F0, 2'b10, 1, "R4");
    issue(0, 3'd1, 16'hFFFF, 2'b11, 0, "R2");
    issue(1, 3'd0, 16'hFFFF, 2'b11, 0, "R10");
    issue(1, 3'd5, 16'hFFFF, 2'b11, 1, "R10");
    issue(1, 3'd6, 16'hFFFF, 2'b11, 1, "R10");
    issue(1, 3'd2, 16'h3C3C, 2'b11, 0, "R5");
    issue(1, 3'd1, 16'hFFFF, 2'b11, 1, "R6");
    issue(1, 3'd1, 16'h0000, 2'b11, 1, "R6");
    issue(1, 3'd1, 16'h0000, 2'b01, 1, "R6");
    issue(1, 3'd1, 16'h0000, 2'b11, 0, "R3");
    issue(1, 3'd3, 16'h0000, 2'b11, 0, "R7");
    issue(1, 3'd1, 16'h5555, 2'b11, 1, "R7");
    issue(1, 3'd7, 16'h0000, 2'b11, 0, "R10");
    issue(1, 3'd1, 16'h1111, 2'b11, 1, "R10");
    issue(1, 3'd2, 16'h0F0F, 2'b11, 0, "R5");
    issue(1, 3'd1, 16'hFFFF, 2'b11, 1, "R6");
    issue(1, 3'd4, 16'h0000, 2'b11, 0, "R8");
    issue(1, 3'd1, 16'h8001, 2'b11, 1, "R8");
    issue(1, 3'd1, 16'h6006, 2'b10, 1, "R8");
    issue(1, 3'd4, 16'h0000, 2'b11, 0, "R8");
    issue(1, 3'd1, 16'h0FF0, 2'b11, 1, "R4");
    issue(0, 3'd0, 16'h0000, 2'b00, 0, "R2");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule